// File: doc/BRIEF.md
# Write Status Polling Responder

This block sits in the read path of an emulated byte-wide nonvolatile memory. While the write controller reports that an internal programming cycle is running, a host read gets a status word instead of array contents. That status word carries two early-completion indicators. The top bit is the inverse of the top bit of the last byte written. The next bit changes value once for every separate read access. The remaining bits read as zero. When the controller reports idle, reads pass the array data through unchanged.

A read access exists while the active-low chip select and the active-low output enable are both low. Outside an access the block drops its output qualifier, which stands for the high-impedance bus, and holds the data lines at zero. Every output is registered. The value seen after a rising clock edge reflects the inputs that were sampled at that edge.

Top module: `wr_poll_status`

## Requirements
- R1: After reset, `rd_data_en` is 0 and `rd_data` is 0. The internal toggle state starts at 0, so the first read access that starts while busy returns bit 6 = 1.
- R2: After an edge at which `ce_n` and `oe_n` were both sampled low, `rd_data_en` is 1. After any other edge, `rd_data_en` is 0 and `rd_data` is all zeros.
- R3: During an access with `prog_busy` sampled low, `rd_data` equals the `array_rd_data` sampled at that same edge.
- R4: During an access with `prog_busy` sampled high, `rd_data[7]` equals the inverse of the sampled `last_wr_data[7]`.
- R5: The toggle state inverts at the first edge of a read access (both enables low, and they were not both low at the previous edge) if `prog_busy` is high at that edge. During a busy access, `rd_data[6]` shows the toggle state, so it stays constant for as long as the enables are held low.
- R6: During an access with `prog_busy` high, `rd_data[5:0]` is 0.
- R7: Accesses that start while `prog_busy` is low leave the toggle state unchanged. The next busy access therefore returns the inverse of the last bit 6 that was shown.
- R8: If `prog_busy` falls during a held access, the output switches to `array_rd_data` one edge later, and bit 7 then shows the true stored value.
- R9: If `prog_busy` rises during an access that is already under way, the output shows the status word, but the toggle state does not invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_busy | input | 1 | Internal programming cycle in progress |
| last_wr_data | input | 8 | Last byte accepted by the write controller |
| array_rd_data | input | 8 | Array contents at the current read address |
| rd_data | output | 8 | Read data; all zeros when not driven |
| rd_data_en | output | 1 | Output driven (0 stands for high impedance) |

## Verification
The start of a read access and a change of the busy flag can fall on the same edge. That edge decides both whether the toggle state inverts and which view is returned. The bench forces this directly: it opens an access on the very edge where busy drops, and again on the edge where busy rises. Random stimulus also produces such coincidences many times. In each case the bench judges the result with a reference model that uses only the busy value sampled at the starting edge. That model expects no inversion and array data in the first case, and an inversion together with the status word in the second. Separate directed steps flip busy in the middle of a held access, to separate those cases from an access that starts on the edge.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

    typedef enum logic [1:0] {
        VIEW_OFF    = 2'd0,
        VIEW_ARRAY  = 2'd1,
        VIEW_STATUS = 2'd2
    } view_e;

    typedef struct packed {
        logic act;
    } acc_st_t;

    typedef struct packed {
        logic tog;
    } tog_st_t;

endpackage

// File: rtl/wsp_access_detect.sv
module wsp_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic acc_on,
    output logic acc_start
);
    import wsp_pkg::*;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        acc_on    = !ce_n && !oe_n;
        acc_start = acc_on && !st_q.act;
        st_d.act  = acc_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wsp_toggle_gen.sv
module wsp_toggle_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_start,
    input  logic busy,
    output logic tog_next
);
    import wsp_pkg::*;

    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_start && busy) st_d.tog = !st_q.tog;
        tog_next = st_d.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wsp_out_stage.sv
module wsp_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_on,
    input  logic              busy,
    input  logic              tog_next,
    input  logic [DATA_W-1:0] last_wr_data,
    input  logic [DATA_W-1:0] array_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_en
);
    import wsp_pkg::*;

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] data;
        view_e             view;
    } out_st_t;

    out_st_t st_d, st_q;
    logic [DATA_W-1:0] status_word;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_stat
            if (b == POLL_BIT) begin : g_poll
                assign status_word[b] = !last_wr_data[POLL_BIT];
            end else if (b == TOG_BIT) begin : g_tog
                assign status_word[b] = tog_next;
            end else begin : g_resv
                assign status_word[b] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!acc_on)   st_d.view = VIEW_OFF;
        else if (busy) st_d.view = VIEW_STATUS;
        else           st_d.view = VIEW_ARRAY;
        unique case (st_d.view)
            VIEW_STATUS: begin st_d.en = 1'b1; st_d.data = status_word;   end
            VIEW_ARRAY:  begin st_d.en = 1'b1; st_d.data = array_rd_data; end
            default:     begin st_d.en = 1'b0; st_d.data = '0;            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{en: 1'b0, data: '0, view: VIEW_OFF};
        else        st_q <= st_d;
    end

    assign rd_data    = st_q.data;
    assign rd_data_en = st_q.en;
endmodule

// File: rtl/wr_poll_status.sv
module wr_poll_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_busy,
    input  logic [DATA_W-1:0] last_wr_data,
    input  logic [DATA_W-1:0] array_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_en
);
    logic acc_on, acc_start, tog_next;

    wsp_access_detect u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .acc_on    (acc_on),
        .acc_start (acc_start)
    );

    wsp_toggle_gen u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .busy      (prog_busy),
        .tog_next  (tog_next)
    );

    wsp_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_on        (acc_on),
        .busy          (prog_busy),
        .tog_next      (tog_next),
        .last_wr_data  (last_wr_data),
        .array_rd_data (array_rd_data),
        .rd_data       (rd_data),
        .rd_data_en    (rd_data_en)
    );
endmodule

// File: rtl/wr_poll_status_chk.sv
module wr_poll_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              prog_busy,
    input logic [DATA_W-1:0] last_wr_data,
    input logic [DATA_W-1:0] array_rd_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_data_en
);
    logic rd_act;
    assign rd_act = !ce_n && !oe_n;

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_en |-> (rd_data == '0));

    p_en_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> rd_data_en);

    p_en_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> !rd_data_en);

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !prog_busy) |=> (rd_data == $past(array_rd_data)));

    p_poll_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy) |=> (rd_data[DATA_W-1] != $past(last_wr_data[DATA_W-1])));

    p_resv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy) |=> (rd_data[DATA_W-3:0] == '0));

    p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && $past(rd_act) && prog_busy && $past(prog_busy))
            |=> $stable(rd_data[DATA_W-2]));
endmodule

bind wr_poll_status wr_poll_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/wr_poll_status_test.sv
module wr_poll_status_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       prog_busy = 1'b0;
    logic [7:0] last_wr_data = 8'h00;
    logic [7:0] array_rd_data = 8'h00;
    logic [7:0] rd_data;
    logic       rd_data_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit m_tog = 0;
    bit m_prev_act = 0;
    logic [7:0] m_exp;
    bit m_en;

    wr_poll_status uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .prog_busy     (prog_busy),
        .last_wr_data  (last_wr_data),
        .array_rd_data (array_rd_data),
        .rd_data       (rd_data),
        .rd_data_en    (rd_data_en)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] status_of(input logic [7:0] lwd, input bit tog);
        return {~lwd[7], tog, 6'b0};
    endfunction

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit c, input bit o, input bit b,
                        input logic [7:0] lwd, input logic [7:0] ard);
        bit act, start;
        ce_n = c; oe_n = o; prog_busy = b;
        last_wr_data = lwd; array_rd_data = ard;
        @(posedge clk);
        act = !c && !o;
        start = act && !m_prev_act;
        if (start && b) m_tog = !m_tog;
        m_prev_act = act;
        m_en = act;
        m_exp = !act ? 8'h00 : (b ? status_of(lwd, m_tog) : ard);
        @(negedge clk);
        check("R2 enable", {7'b0, rd_data_en}, {7'b0, m_en});
        if (!act)      check("R2 idle data", rd_data, 8'h00);
        else if (b) begin
            check("R4 poll bit", {7'b0, rd_data[7]}, {7'b0, m_exp[7]});
            check("R5 toggle bit", {7'b0, rd_data[6]}, {7'b0, m_exp[6]});
            check("R6 reserved", {2'b0, rd_data[5:0]}, 8'h00);
        end else       check("R3 pass-through", rd_data, ard);
    endtask

    initial begin
        bit last6;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 reset en", {7'b0, rd_data_en}, 8'h00);
        check("R1 reset data", rd_data, 8'h00);
        rst_n = 1'b1;
        m_tog = 0; m_prev_act = 0;
        @(negedge clk);

        // R1: first busy access shows toggle 1
        step(0, 0, 1, 8'h35, 8'hAA);
        check("R1 first toggle", {7'b0, rd_data[6]}, 8'h01);
        check("R4 inv of 0", {7'b0, rd_data[7]}, 8'h01);
        step(0, 0, 1, 8'h35, 8'hAA);          // held: no flip
        check("R5 held", {7'b0, rd_data[6]}, 8'h01);
        step(1, 0, 1, 8'hB5, 8'hAA);          // gap
        step(0, 0, 1, 8'hB5, 8'hAA);          // new access: flip to 0
        check("R5 second access", rd_data, 8'h00);

        // R7: idle accesses keep toggle
        last6 = rd_data[6];
        step(0, 1, 0, 8'h00, 8'h11);
        step(0, 0, 0, 8'h00, 8'h5C);
        step(1, 1, 0, 8'h00, 8'h5C);
        step(0, 0, 0, 8'h00, 8'h77);
        step(1, 0, 0, 8'h00, 8'h77);
        step(0, 0, 1, 8'h80, 8'h77);
        check("R7 toggle kept", {7'b0, rd_data[6]}, {7'b0, ~last6});

        // R8: busy falls during held access
        step(0, 0, 1, 8'h80, 8'hC3);
        step(0, 0, 0, 8'h80, 8'hC3);
        check("R8 array after busy drop", rd_data, 8'hC3);
        check("R8 true bit7", {7'b0, rd_data[7]}, 8'h01);
        step(1, 1, 0, 8'h80, 8'hC3);

        // R9: busy rises mid-access, no flip
        step(0, 0, 0, 8'h00, 8'h3C);
        last6 = m_tog;
        step(0, 0, 1, 8'h00, 8'h3C);
        check("R9 status no flip", rd_data, {1'b1, last6, 6'b0});
        step(1, 1, 1, 8'h00, 8'h3C);

        // same-edge: access start with busy low, then with busy high
        step(0, 0, 0, 8'h00, 8'h96);
        check("R8 start on busy drop", rd_data, 8'h96);
        step(1, 1, 0, 8'h00, 8'h96);
        last6 = m_tog;
        step(0, 0, 1, 8'h7F, 8'h96);
        check("R5 start on busy rise", rd_data, {1'b1, ~last6, 6'b0});
        step(1, 1, 0, 8'h00, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 2) == 1,
                 8'($urandom), 8'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule